// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one complete operation on an asynchronous 8-bit NAND flash device for each request it accepts. The supported operations are device reset, identification read, page read, page program, block erase and status read. For each operation the sequencer drives the chip-select, command-latch, address-latch, write-strobe, read-strobe and write-protect pins and the data bus in the correct order. Where the device signals that it is busy, the sequencer waits on the ready/busy line. Firmware only supplies an operation code, a column and a row, so it carries no timing duties.

Page data moves through a byte-wide buffer port. During a program the sequencer reads bytes from the buffer at `buf_addr_o`. During any read-type operation it writes each returned byte to the buffer at `buf_addr_o`. The strobe low and high widths and the busy timeout are parameters given in clock cycles. Each operation has a fixed byte budget: a program sends 2119 bytes, a page read sends 7 bytes and returns 2112, an erase sends 5 bytes, and a status read sends 1 byte and returns 1. These counts apply at the default page size.

Top module: `nand_seq`

## Requirements
- R1: Operation code 0 (reset) sends the single command byte FFh. It then waits for ready/busy to fall and rise again before it completes with `err_o` low.
- R2: Until a reset has completed without error, a request for any other operation is answered with a one-cycle `done_o` and `err_o` high, and no strobe pulse occurs. The same answer is given at any time for an operation code above 5.
- R3: Operation code 1 (identification) sends command 90h and one address byte 00h. It then reads ID_BYTES bytes into buffer addresses 0 upward.
- R4: Operation code 2 (page read) sends command 00h and then five address bytes: column low, column high, row bits 7:0, row bits 15:8, row bits 23:16. It then sends command 30h and waits for ready/busy to fall and rise. Finally it reads PAGE_BYTES bytes into buffer addresses 0 upward, in order.
- R5: Operation code 3 (program) sends command 80h, the five address bytes in the R4 order, and the PAGE_BYTES buffer bytes from address 0 upward. It then sends command 10h and waits for ready/busy to fall and rise.
- R6: Operation code 4 (erase) sends command 60h, the three row bytes with the lowest first, and command D0h. It then waits for ready/busy to fall and rise.
- R7: Operation code 5 (status) sends command 70h and reads one byte into buffer address 0.
- R8: Command bytes are latched with CLE high and ALE low. Address bytes are latched with ALE high and CLE low. Data bytes are latched with both low. Every byte is latched on a rising edge of the write strobe, with the bus and latch pins stable at that edge. The data bus output enable is low whenever the read strobe is low.
- R9: The write-protect pin `nand_wp_no` is high only while a program or erase operation is in progress. It is low at all other times.
- R10: If a busy wait lasts TIMEOUT cycles without the fall-then-rise of ready/busy, the operation completes with `err_o` high. The sequencer then accepts the next request normally.
- R11: Each write or read strobe pulse is low for exactly T_LO cycles. Between pulses both strobes stay high for at least T_HI cycles.
- R12: After reset and whenever `busy_o` is low, chip enable is high and both strobes are high. Chip enable is low while bytes are transferred.
- R13: `done_o` is a one-cycle pulse at the end of each operation. A request made while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start request, sampled while idle |
| op_i | input | 3 | Operation code (0 reset, 1 ID, 2 read, 3 program, 4 erase, 5 status) |
| col_i | input | 16 | Column address |
| row_i | input | 24 | Row (page/block) address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| buf_addr_o | output | $clog2(PAGE_BYTES) | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer read data for program, combinational on buf_addr_o |
| buf_we_o | output | 1 | Buffer write strobe for returned bytes |
| buf_wdata_o | output | 8 | Returned byte |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_wp_no | output | 1 | Write protect, active low |
| nand_io_o | output | 8 | Data bus out |
| nand_io_oe_o | output | 1 | Data bus output enable |
| nand_io_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Ready/busy, low when busy |

## Verification
Every operation code is run against a behavioural flash model, so each of the six byte budgets is compared latch by latch with its CLE/ALE classification. Row and column values use distinct bytes in every position, which exposes any swap or mis-ordering of address bytes. The page data patterns depend on the byte index, which exposes an off-by-one in buffer addressing or a lost or extra byte at either end of a page. A ready line held low separates the timeout path from a normal busy wait. Requests made before the first reset, requests with an undefined code, and requests made in the middle of an operation must all leave the bus untouched.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_READ_ID = 3'd1,
    OP_READ    = 3'd2,
    OP_PROG    = 3'd3,
    OP_ERASE   = 3'd4,
    OP_STATUS  = 3'd5
  } nand_op_e;

  // Phase order is the order bytes appear on the bus; next_phase skips empty ones.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD1  = 3'd1,
    PH_ADDR  = 3'd2,
    PH_WDATA = 3'd3,
    PH_CMD2  = 3'd4,
    PH_WAIT  = 3'd5,
    PH_RDATA = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  typedef enum logic [1:0] {RD_NONE, RD_ONE, RD_ID, RD_PAGE} rd_kind_e;

  typedef struct packed {
    logic [7:0] cmd1;
    logic [7:0] cmd2;
    logic       has_cmd2;
    logic [2:0] n_addr;
    logic       wr_page;
    logic       wait_rb;
    rd_kind_e   rd_kind;
    logic       wp_open;
  } op_cfg_t;

  function automatic logic op_valid(logic [2:0] op);
    return op < 3'd6;
  endfunction

  function automatic op_cfg_t op_cfg(logic [2:0] op);
    op_cfg_t c;
    c = '{cmd1: 8'h00, cmd2: 8'h00, has_cmd2: 1'b0, n_addr: 3'd0, wr_page: 1'b0,
          wait_rb: 1'b0, rd_kind: RD_NONE, wp_open: 1'b0};
    case (op)
      OP_RESET:   begin c.cmd1 = 8'hFF; c.wait_rb = 1'b1; end
      OP_READ_ID: begin c.cmd1 = 8'h90; c.n_addr = 3'd1; c.rd_kind = RD_ID; end
      OP_READ:    begin
        c.cmd1 = 8'h00; c.cmd2 = 8'h30; c.has_cmd2 = 1'b1; c.n_addr = 3'd5;
        c.wait_rb = 1'b1; c.rd_kind = RD_PAGE;
      end
      OP_PROG:    begin
        c.cmd1 = 8'h80; c.cmd2 = 8'h10; c.has_cmd2 = 1'b1; c.n_addr = 3'd5;
        c.wr_page = 1'b1; c.wait_rb = 1'b1; c.wp_open = 1'b1;
      end
      OP_ERASE:   begin
        c.cmd1 = 8'h60; c.cmd2 = 8'hD0; c.has_cmd2 = 1'b1; c.n_addr = 3'd3;
        c.wait_rb = 1'b1; c.wp_open = 1'b1;
      end
      OP_STATUS:  begin c.cmd1 = 8'h70; c.rd_kind = RD_ONE; end
      default: ;
    endcase
    return c;
  endfunction

  function automatic phase_e next_phase(phase_e cur, op_cfg_t c);
    logic [7:0] en;
    phase_e     nxt;
    en  = {1'b1, c.rd_kind != RD_NONE, c.wait_rb, c.has_cmd2, c.wr_page,
           c.n_addr != 3'd0, 2'b00};
    nxt = PH_DONE;
    for (int i = 7; i >= 1; i--)
      if (i > int'(cur) && en[i]) nxt = phase_e'(3'(i));
    return nxt;
  endfunction

endpackage

// File: rtl/nand_strobe.sv
module nand_strobe #(
  parameter int unsigned T_LO = 2,
  parameter int unsigned T_HI = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_i,
  output logic we_no,
  output logic re_no,
  output logic idle_o,
  output logic sample_o,
  output logic done_o
);
  localparam int unsigned T_MAX = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int unsigned CW    = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          lo_end, hi_end;

  assign lo_end = (st == S_LO) && (cnt == CW'(T_LO - 1));
  assign hi_end = (st == S_HI) && (cnt == CW'(T_HI - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= S_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin st <= S_LO; cnt <= '0; rd_q <= rd_i; end
        S_LO:   if (lo_end) begin st <= S_HI; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_HI:   if (hi_end) st <= S_IDLE; else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign we_no    = !((st == S_LO) && !rd_q);
  assign re_no    = !((st == S_LO) && rd_q);
  assign idle_o   = (st == S_IDLE);
  assign sample_o = lo_end && rd_q;  // last low cycle: device data settled
  assign done_o   = hi_end;

endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
  parameter int unsigned TIMEOUT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rb_i,
  output logic idle_o,
  output logic done_o,
  output logic err_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {W_IDLE, W_FALL, W_RISE} st_e;

  st_e           st;
  logic [TW-1:0] tmr;
  logic [1:0]    rb_sync;
  logic          rb_s;

  assign rb_s   = rb_sync[1];
  assign idle_o = (st == W_IDLE);
  assign done_o = (st == W_RISE) && rb_s;
  assign err_o  = (st != W_IDLE) && !done_o && (tmr == TW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_sync <= 2'b11;
      st      <= W_IDLE;
      tmr     <= '0;
    end else begin
      rb_sync <= {rb_sync[0], rb_i};
      if (st == W_IDLE) begin
        if (start_i) begin st <= W_FALL; tmr <= '0; end
      end else if (done_o || err_o) begin
        st <= W_IDLE;
      end else begin
        tmr <= tmr + 1'b1;
        if (st == W_FALL && !rb_s) st <= W_RISE;
      end
    end
  end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 2112,
  parameter int unsigned ID_BYTES   = 4,
  parameter int unsigned T_LO       = 2,
  parameter int unsigned T_HI       = 2,
  parameter int unsigned TIMEOUT    = 100000,
  localparam int unsigned BUF_AW    = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [15:0]       col_i,
  input  logic [23:0]       row_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic              nand_wp_no,
  output logic [7:0]        nand_io_o,
  output logic              nand_io_oe_o,
  input  logic [7:0]        nand_io_i,
  input  logic              nand_rb_i
);

  phase_e            phase;
  op_cfg_t           cfg;
  logic [2:0]        op_q;
  logic [15:0]       col_q;
  logic [23:0]       row_q;
  logic [BUF_AW-1:0] cnt;
  logic              err_q, reset_seen;

  logic stb_start, stb_idle, stb_sample, stb_done;
  logic rb_start, rb_idle, rb_done, rb_err;
  logic byte_ph, last, reject, active;
  int unsigned len;
  logic [2:0]  ab_idx;
  logic [7:0]  addr_byte;

  assign byte_ph = (phase == PH_CMD1) || (phase == PH_ADDR) || (phase == PH_WDATA) ||
                   (phase == PH_CMD2) || (phase == PH_RDATA);
  assign active  = (phase != PH_IDLE) && (phase != PH_DONE);
  assign reject  = !op_valid(op_i) || (!reset_seen && op_i != OP_RESET);

  always_comb begin
    case (phase)
      PH_ADDR:  len = 32'(cfg.n_addr);
      PH_WDATA: len = PAGE_BYTES;
      PH_RDATA: case (cfg.rd_kind)
                  RD_ID:   len = ID_BYTES;
                  RD_PAGE: len = PAGE_BYTES;
                  default: len = 1;
                endcase
      default:  len = 1;
    endcase
  end
  assign last = (cnt == BUF_AW'(len - 1));

  // Erase carries row bytes only; skip the two column slots.
  always_comb begin
    ab_idx = (cfg.n_addr == 3'd3) ? 3'(cnt) + 3'd2 : 3'(cnt);
    case (ab_idx)
      3'd0:    addr_byte = col_q[7:0];
      3'd1:    addr_byte = col_q[15:8];
      3'd2:    addr_byte = row_q[7:0];
      3'd3:    addr_byte = row_q[15:8];
      default: addr_byte = row_q[23:16];
    endcase
    if (cfg.n_addr == 3'd1) addr_byte = 8'h00;
  end

  assign stb_start = byte_ph && stb_idle;
  assign rb_start  = (phase == PH_WAIT) && rb_idle;

  nand_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (stb_start),
    .rd_i     (phase == PH_RDATA),
    .we_no    (nand_we_no),
    .re_no    (nand_re_no),
    .idle_o   (stb_idle),
    .sample_o (stb_sample),
    .done_o   (stb_done)
  );

  nand_rb_wait #(.TIMEOUT(TIMEOUT)) u_rb_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rb_start),
    .rb_i    (nand_rb_i),
    .idle_o  (rb_idle),
    .done_o  (rb_done),
    .err_o   (rb_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase      <= PH_IDLE;
      cfg        <= '0;
      op_q       <= '0;
      col_q      <= '0;
      row_q      <= '0;
      cnt        <= '0;
      err_q      <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (req_i) begin
          op_q  <= op_i;
          cfg   <= op_cfg(op_i);
          col_q <= col_i;
          row_q <= row_i;
          cnt   <= '0;
          err_q <= reject;
          phase <= reject ? PH_DONE : PH_CMD1;
        end
        PH_WAIT: begin
          if (rb_err) begin
            phase <= PH_DONE;
            err_q <= 1'b1;
          end else if (rb_done) begin
            phase <= next_phase(PH_WAIT, cfg);
          end
        end
        PH_DONE: begin
          phase <= PH_IDLE;
          if (op_q == OP_RESET && !err_q) reset_seen <= 1'b1;
        end
        default: if (stb_done) begin
          if (last) begin
            phase <= next_phase(phase, cfg);
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_CMD1:  nand_io_o = cfg.cmd1;
      PH_CMD2:  nand_io_o = cfg.cmd2;
      PH_ADDR:  nand_io_o = addr_byte;
      PH_WDATA: nand_io_o = buf_rdata_i;
      default:  nand_io_o = 8'h00;
    endcase
  end

  assign nand_io_oe_o = byte_ph && (phase != PH_RDATA);
  assign nand_cle_o   = (phase == PH_CMD1) || (phase == PH_CMD2);
  assign nand_ale_o   = (phase == PH_ADDR);
  assign nand_ce_no   = !active;
  assign nand_wp_no   = active && cfg.wp_open;

  assign busy_o      = (phase != PH_IDLE);
  assign done_o      = (phase == PH_DONE);
  assign err_o       = (phase == PH_DONE) && err_q;
  assign buf_addr_o  = cnt;
  assign buf_we_o    = (phase == PH_RDATA) && stb_sample;
  assign buf_wdata_o = nand_io_i;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       nand_ce_no,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic       nand_wp_no,
  input logic [7:0] nand_io_o,
  input logic       nand_io_oe_o
);

  assert_latch_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  assert_we_edge_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> ($stable(nand_io_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));

  assert_bus_turn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_io_oe_o);

  assert_wp_scope_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_wp_no |-> busy_o);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  assert_idle_pins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (nand_ce_no && nand_we_no && nand_re_no));

  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .nand_ce_no   (nand_ce_no),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_wp_no   (nand_wp_no),
  .nand_io_o    (nand_io_o),
  .nand_io_oe_o (nand_io_oe_o)
);

// File: tb/nand_seq_tb_top.sv
module nand_seq_tb_top;
  import nand_seq_pkg::*;

  localparam int PAGE = 2112;
  localparam int IDB  = 4;
  localparam int TLO  = 2;
  localparam int THI  = 1;
  localparam int TMO  = 400;
  localparam int BUSY = 30;
  localparam int AW   = $clog2(PAGE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] op_in = 3'd0;
  logic [15:0] col_in = '0;
  logic [23:0] row_in = '0;
  logic busy, done, err;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_rdata, buf_wdata, io_o, io_in;
  logic buf_we, ce_n, cle, ale, we_n, re_n, wp_n, io_oe;
  logic rb_q = 1'b1;

  always #10 clk = ~clk;

  nand_seq #(
    .PAGE_BYTES(PAGE), .ID_BYTES(IDB), .T_LO(TLO), .T_HI(THI), .TIMEOUT(TMO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op_in), .col_i(col_in), .row_i(row_in),
    .busy_o(busy), .done_o(done), .err_o(err),
    .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_wp_no(wp_n), .nand_io_o(io_o), .nand_io_oe_o(io_oe), .nand_io_i(io_in), .nand_rb_i(rb_q)
  );

  function automatic logic [7:0] pat_rd(int i); return 8'(i * 7 + 3); endfunction
  function automatic logic [7:0] pat_tx(int i); return 8'(i * 13 + 1); endfunction
  function automatic logic [7:0] id_b(int i);   return 8'(160 + i * 17); endfunction

  logic [7:0] tx_mem [PAGE];
  assign buf_rdata = tx_mem[buf_addr];

  // flash model state
  int   rd_idx = 0;
  int   mode = 0;        // 0 page, 1 id, 2 status
  int   rb_dly = 0;
  int   busy_left = 0;
  bit   stuck = 1'b0;
  logic [7:0] model_byte;

  always_comb begin
    case (mode)
      1:       model_byte = id_b(rd_idx);
      2:       model_byte = 8'hE0;
      default: model_byte = pat_rd(rd_idx);
    endcase
  end
  assign io_in = !re_n ? model_byte : 8'h00;

  // scoreboard: {kind[1:0], addr[11:0], val[7:0]}; kind 0 cmd, 1 addr, 2 data in, 3 returned
  logic [21:0] exp_q[$];
  int    n_chk = 0, n_fail = 0;
  string cur_rq = "R12";
  bit    cur_wp = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] k, input int a, input logic [7:0] v);
    exp_q.push_back({k, 12'(a), v});
  endtask

  // monitor
  logic prev_we = 1'b1, prev_re = 1'b1;
  int   we_lo = 0, re_lo = 0, both_hi = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [21:0] e;
      logic [1:0]  kind;
      if (buf_we) begin
        if (exp_q.size() == 0) chk(1'b0, cur_rq, "unexpected buffer write", int'(buf_wdata), 0);
        else begin
          e = exp_q.pop_front();
          chk(e[21:20] == 2'd3, cur_rq, "returned byte out of turn", int'(e[21:20]), 3);
          chk(e[19:8] == 12'(buf_addr), cur_rq, "buffer address", int'(buf_addr), int'(e[19:8]));
          chk(e[7:0] == buf_wdata, cur_rq, "returned byte", int'(buf_wdata), int'(e[7:0]));
        end
      end
      if (!we_n || !re_n) begin
        if (prev_we && prev_re) begin
          chk(both_hi >= THI, "R11", "strobe high gap", both_hi, THI);
        end
        both_hi = 0;
      end else both_hi++;
      if (!we_n) we_lo++;
      else if (!prev_we) begin
        chk(we_lo == TLO, "R11", "WE low width", we_lo, TLO);
        chk(!ce_n, "R12", "CE low at latch", int'(ce_n), 0);
        chk(wp_n == cur_wp, "R9", "WP level", int'(wp_n), int'(cur_wp));
        kind = cle ? 2'd0 : (ale ? 2'd1 : 2'd2);
        if (exp_q.size() == 0) chk(1'b0, "R13", "unexpected latch", int'(io_o), 0);
        else begin
          e = exp_q.pop_front();
          chk(e[21:20] == kind, "R8", "latch kind", int'(kind), int'(e[21:20]));
          chk(e[7:0] == io_o, cur_rq, "latched byte", int'(io_o), int'(e[7:0]));
        end
        if (cle) begin
          case (io_o)
            8'hFF, 8'h30, 8'h10, 8'hD0: rb_dly = 3;
            8'h90: begin mode = 1; rd_idx = 0; end
            8'h70: begin mode = 2; rd_idx = 0; end
            8'h00: begin mode = 0; rd_idx = 0; end
            default: ;
          endcase
        end
        we_lo = 0;
      end
      if (!re_n) re_lo++;
      else if (!prev_re) begin
        chk(re_lo == TLO, "R11", "RE low width", re_lo, TLO);
        rd_idx++;
        re_lo = 0;
      end
      if (rb_dly > 0) begin
        rb_dly--;
        if (rb_dly == 0) begin rb_q = 1'b0; busy_left = BUSY; end
      end else if (busy_left > 0) busy_left--;
      else if (!stuck) rb_q = 1'b1;
      prev_we = we_n;
      prev_re = re_n;
    end
  end

  task automatic push_addr5(input logic [15:0] col, input logic [23:0] row);
    push(2'd1, 0, col[7:0]);   push(2'd1, 0, col[15:8]);
    push(2'd1, 0, row[7:0]);   push(2'd1, 0, row[15:8]); push(2'd1, 0, row[23:16]);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] col, input logic [23:0] row,
                        input bit expect_bus, input bit exp_err, input string rq);
    int w;
    cur_rq = rq;
    cur_wp = (op == OP_PROG) || (op == OP_ERASE);
    if (expect_bus) begin
      case (op)
        OP_RESET: push(2'd0, 0, 8'hFF);
        OP_READ_ID: begin
          push(2'd0, 0, 8'h90); push(2'd1, 0, 8'h00);
          for (int i = 0; i < IDB; i++) push(2'd3, i, id_b(i));
        end
        OP_READ: begin
          push(2'd0, 0, 8'h00); push_addr5(col, row); push(2'd0, 0, 8'h30);
          for (int i = 0; i < PAGE; i++) push(2'd3, i, pat_rd(i));
        end
        OP_PROG: begin
          push(2'd0, 0, 8'h80); push_addr5(col, row);
          for (int i = 0; i < PAGE; i++) push(2'd2, 0, tx_mem[i]);
          push(2'd0, 0, 8'h10);
        end
        OP_ERASE: begin
          push(2'd0, 0, 8'h60);
          push(2'd1, 0, row[7:0]); push(2'd1, 0, row[15:8]); push(2'd1, 0, row[23:16]);
          push(2'd0, 0, 8'hD0);
        end
        OP_STATUS: begin push(2'd0, 0, 8'h70); push(2'd3, 0, 8'hE0); end
        default: ;
      endcase
    end
    @(negedge clk);
    req = 1'b1; op_in = op; col_in = col; row_in = row;
    @(negedge clk);
    req = 1'b0;
    w = 0;
    while (!done && w < 30000) begin @(negedge clk); w++; end
    chk(done, rq, "completion", int'(done), 1);
    chk(err == exp_err, rq, "err_o", int'(err), int'(exp_err));
    @(negedge clk);
    chk(!done, "R13", "done width", int'(done), 0);
    chk(exp_q.size() == 0, rq, "bytes missing", exp_q.size(), 0);
    chk(ce_n && !wp_n && !busy, "R12", "idle pins", int'({ce_n, wp_n, busy}), 4);
    exp_q.delete();
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGE; i++) tx_mem[i] = pat_tx(i);
    repeat (3) @(negedge clk);
    chk(ce_n, "R12", "reset CE", int'(ce_n), 1);
    chk(we_n && re_n, "R12", "reset strobes", int'({we_n, re_n}), 3);
    chk(!wp_n, "R9", "reset WP", int'(wp_n), 0);
    chk(!busy && !done, "R13", "reset busy/done", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(OP_STATUS, 16'h0, 24'h0, 1'b0, 1'b1, "R2");
    run_op(OP_RESET, 16'h0, 24'h0, 1'b1, 1'b0, "R1");
    run_op(OP_STATUS, 16'h0, 24'h0, 1'b1, 1'b0, "R7");
    run_op(OP_READ_ID, 16'h0, 24'h0, 1'b1, 1'b0, "R3");
    run_op(OP_ERASE, 16'h0, 24'h012345, 1'b1, 1'b0, "R6");
    fork
      run_op(OP_PROG, 16'h0201, 24'h0A0B0C, 1'b1, 1'b0, "R5");
      begin
        repeat (60) @(negedge clk);
        req = 1'b1; op_in = OP_ERASE;  // R13: ignored while busy
        @(negedge clk);
        req = 1'b0;
      end
    join
    run_op(OP_READ, 16'h0834, 24'hABCDEF, 1'b1, 1'b0, "R4");
    run_op(3'd7, 16'h0, 24'h0, 1'b0, 1'b1, "R2");
    stuck = 1'b1;
    run_op(OP_ERASE, 16'h0, 24'h554433, 1'b1, 1'b1, "R10");
    stuck = 1'b0;
    repeat (5) @(negedge clk);
    chk(rb_q, "R10", "model released", int'(rb_q), 1);
    run_op(OP_STATUS, 16'h0, 24'h0, 1'b1, 1'b0, "R10");

    summary();
    $finish;
  end

endmodule